// File: doc/BRIEF.md
# Clock-Calendar Update Engine

This block keeps the time of day and a 100-year calendar. The time is held as seconds, minutes and hours, with day of week, day of month, month and a two-digit year. Three alarm bytes cover seconds, minutes and hours. A base tick input drives a phase counter. Once every `TICKS_PER_SEC` ticks, one update edge advances the whole time. All bytes are stored and counted in the format software selected, either BCD or binary. Hours run in 12-hour or 24-hour form.

The time exists in two places. There is a working copy that always counts. There is also a user copy, which is what the register port returns. Software can freeze the user copy while it reads or programs the time. An update-in-progress flag rises a set number of ticks before each update. After the update, a completion flag and, on a match, an alarm flag are latched. Reading the status byte clears both latched flags.

Top module: `rtc_cal_engine`

## Requirements
- R1: Register map (addr): 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10 control, 11 status. Any other address reads 0x00.
- R2: On each update, seconds advance by one. Seconds carry into minutes and minutes carry into hours. In binary the seconds and minutes run 0x00..0x3B and 24-hour hours run 0x00..0x17. In BCD the same fields run 0x00..0x59 and 0x00..0x23.
- R3: Control bit 0 selects binary (1) or BCD (0) for every byte. Control bit 1 selects 24-hour (1) or 12-hour (0) mode.
- R4: In 12-hour mode, hours are 1..12 and bit 7 set means PM. 11 AM advances to 12 PM (0x92 BCD, 0x8C binary). 11 PM advances to 12 AM (0x12 BCD, 0x0C binary) and starts a new day.
- R5: A new day advances the day of week with 7 wrapping to 1. Days of month run from 1 to the month length, then month 1..12 and year 0..99, with year 99 wrapping to 00.
- R6: Month lengths are 30 for months 4, 6, 9 and 11. February has 29 days when the year value is a multiple of 4, including 00, and 28 days otherwise. All other months have 31 days.
- R7: Status bit 0 (update in progress) rises on the tick that leaves `LEAD_TICKS` ticks before the update. It falls on the update edge, and on that same edge status bit 1 (update complete) is set.
- R8: While control bit 2 (inhibit) is 1, the time bytes read back stay frozen and the working copy keeps counting. The first update after the bit clears shows the working time.
- R9: A write to a time byte lands in both copies. It reads back at once, including while inhibit is set.
- R10: The alarm is met when each alarm byte equals the new time byte or has both top bits set (0xC0..0xFF). A met alarm sets status bit 2 at the update.
- R11: A read strobe on the status address returns the flags and then clears bits 1 and 2. A flag being set on the same edge wins over the clear.
- R12: After reset the time is 00:00:00 with day of week 1, date 1, month 1, year 00 and all alarms 0x00. The control byte reads 0x02 (BCD, 24-hour) and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle base tick pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on status read) |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |

## Verification
The bench builds the engine with `TICKS_PER_SEC` = 4 and `LEAD_TICKS` = 2. A whole second then takes eight clocks, so every rollover chain can be reached by stepping single seconds from times loaded just below a boundary. The update-in-progress window is two ticks wide. This lets the bench observe the flag low, rising and high before the update edge inside one short period. Random times in both data formats and both hour modes are mixed with directed cases: year end, leap and non-leap Februaries, noon and midnight in 12-hour mode, inhibit, and alarm wildcards.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tm_t;

  localparam tm_t TM_RST = '{yr: 8'h00, mon: 8'h01, dom: 8'h01, dow: 8'h01,
                             hr: 8'h00, min: 8'h00, sec: 8'h00};

  localparam logic [3:0] A_SEC = 4'd0, A_ASEC = 4'd1, A_MIN = 4'd2, A_AMIN = 4'd3;
  localparam logic [3:0] A_HR = 4'd4, A_AHR = 4'd5, A_DOW = 4'd6, A_DOM = 4'd7;
  localparam logic [3:0] A_MON = 4'd8, A_YR = 4'd9, A_CTL = 4'd10, A_STAT = 4'd11;

  // stored byte -> plain number
  function automatic logic [6:0] dec_val(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : (7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
  endfunction

  // plain number -> stored byte
  function automatic logic [7:0] enc_val(input logic [6:0] n, input logic bin);
    logic [7:0] w;
    w = {1'b0, n};
    return bin ? w : ((w / 8'd10) * 8'd16 + (w % 8'd10));
  endfunction

  // stored hour -> 0..23
  function automatic logic [6:0] hr_to24(input logic [7:0] v, input logic bin, input logic h24);
    logic [6:0] h;
    if (h24) return dec_val(v, bin);
    h = dec_val({1'b0, v[6:0]}, bin);
    if (h == 7'd12) h = 7'd0;
    return v[7] ? h + 7'd12 : h;
  endfunction

  // 0..23 -> stored hour
  function automatic logic [7:0] hr_from24(input logic [6:0] h, input logic bin, input logic h24);
    logic [6:0] k;
    logic [7:0] e;
    if (h24) return enc_val(h, bin);
    k = (h >= 7'd12) ? h - 7'd12 : h;
    if (k == 7'd0) k = 7'd12;
    e = enc_val(k, bin);
    e[7] = (h >= 7'd12);
    return e;
  endfunction

  function automatic logic [6:0] days_in(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2: return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default: return 7'd31;
    endcase
  endfunction

  function automatic logic alarm_hit(input logic [7:0] a, input logic [7:0] c);
    return (a[7:6] == 2'b11) || (a == c);
  endfunction

  function automatic tm_t put_byte(input tm_t t, input logic [3:0] a, input logic [7:0] d);
    tm_t r;
    r = t;
    case (a)
      A_SEC: r.sec = d;
      A_MIN: r.min = d;
      A_HR:  r.hr  = d;
      A_DOW: r.dow = d;
      A_DOM: r.dom = d;
      A_MON: r.mon = d;
      A_YR:  r.yr  = d;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_phase.sv
`timescale 1ns/1ps
module rtc_phase #(
  parameter int TICKS_PER_SEC = 1024,
  parameter int LEAD_TICKS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic upd_go,
  output logic uip
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WARN = CW'(TICKS_PER_SEC - LEAD_TICKS - 1);

  logic [CW-1:0] cnt;

  assign upd_go = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      uip <= 1'b0;
    end else if (tick) begin
      cnt <= upd_go ? '0 : cnt + 1'b1;
      if (upd_go) uip <= 1'b0;
      else if (cnt == WARN) uip <= 1'b1;
    end
  end

  // R7
  uip_before_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |-> uip);
  // R7
  uip_clear_at_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> $past(upd_go));
endmodule

// File: rtl/rtc_advance.sv
`timescale 1ns/1ps
module rtc_advance
  import rtc_pkg::*;
(
  input  tm_t  cur,
  input  logic bin,
  input  logic h24,
  output tm_t  nxt,
  output logic sec_wrap,
  output logic min_wrap,
  output logic day_wrap,
  output logic mon_wrap,
  output logic yr_wrap
);
  logic [6:0] s, m, h, dw, d, mo, y;

  always_comb begin
    s  = dec_val(cur.sec, bin);
    m  = dec_val(cur.min, bin);
    h  = hr_to24(cur.hr, bin, h24);
    dw = dec_val(cur.dow, bin);
    d  = dec_val(cur.dom, bin);
    mo = dec_val(cur.mon, bin);
    y  = dec_val(cur.yr, bin);

    sec_wrap = (s >= 7'd59);
    min_wrap = sec_wrap && (m >= 7'd59);
    day_wrap = min_wrap && (h >= 7'd23);
    mon_wrap = day_wrap && (d >= days_in(mo, y));
    yr_wrap  = mon_wrap && (mo >= 7'd12);

    nxt = cur;
    nxt.sec = sec_wrap ? 8'h00 : enc_val(s + 7'd1, bin);
    if (sec_wrap) nxt.min = min_wrap ? 8'h00 : enc_val(m + 7'd1, bin);
    if (min_wrap) nxt.hr  = hr_from24(day_wrap ? 7'd0 : h + 7'd1, bin, h24);
    if (day_wrap) begin
      nxt.dow = enc_val((dw >= 7'd7) ? 7'd1 : dw + 7'd1, bin);
      nxt.dom = enc_val(mon_wrap ? 7'd1 : d + 7'd1, bin);
    end
    if (mon_wrap) nxt.mon = enc_val(yr_wrap ? 7'd1 : mo + 7'd1, bin);
    if (yr_wrap)  nxt.yr  = enc_val((y >= 7'd99) ? 7'd0 : y + 7'd1, bin);
  end
endmodule

// File: rtl/rtc_cal_engine.sv
`timescale 1ns/1ps
module rtc_cal_engine
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1024,
  parameter int LEAD_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  tm_t  itm, utm, nxt, itm_d, utm_d;
  logic [7:0] al_sec, al_min, al_hr;
  logic fmt_bin, h24, inhibit, uf, af;
  logic upd_go, uip, hit, rd_clr;
  logic sec_wrap, min_wrap, day_wrap, mon_wrap, yr_wrap;

  rtc_phase #(.TICKS_PER_SEC(TICKS_PER_SEC), .LEAD_TICKS(LEAD_TICKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .upd_go(upd_go), .uip(uip));

  rtc_advance u_adv (
    .cur(itm), .bin(fmt_bin), .h24(h24), .nxt(nxt),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap), .day_wrap(day_wrap),
    .mon_wrap(mon_wrap), .yr_wrap(yr_wrap));

  assign hit    = alarm_hit(al_sec, nxt.sec) && alarm_hit(al_min, nxt.min)
                  && alarm_hit(al_hr, nxt.hr);
  assign rd_clr = rd_en && (addr == A_STAT);

  always_comb begin
    itm_d = upd_go ? nxt : itm;
    utm_d = (upd_go && !inhibit) ? nxt : utm;
    if (wr_en) begin
      itm_d = put_byte(itm_d, addr, wr_data);
      utm_d = put_byte(utm_d, addr, wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itm <= TM_RST;
      utm <= TM_RST;
      al_sec <= 8'h00;
      al_min <= 8'h00;
      al_hr  <= 8'h00;
      fmt_bin <= 1'b0;
      h24     <= 1'b1;
      inhibit <= 1'b0;
      uf <= 1'b0;
      af <= 1'b0;
    end else begin
      itm <= itm_d;
      utm <= utm_d;
      uf  <= upd_go | (uf & ~rd_clr);
      af  <= (upd_go & hit) | (af & ~rd_clr);
      if (wr_en) begin
        case (addr)
          A_ASEC: al_sec <= wr_data;
          A_AMIN: al_min <= wr_data;
          A_AHR:  al_hr  <= wr_data;
          A_CTL:  {inhibit, h24, fmt_bin} <= wr_data[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_SEC:  rd_data = utm.sec;
      A_ASEC: rd_data = al_sec;
      A_MIN:  rd_data = utm.min;
      A_AMIN: rd_data = al_min;
      A_HR:   rd_data = utm.hr;
      A_AHR:  rd_data = al_hr;
      A_DOW:  rd_data = utm.dow;
      A_DOM:  rd_data = utm.dom;
      A_MON:  rd_data = utm.mon;
      A_YR:   rd_data = utm.yr;
      A_CTL:  rd_data = {5'b0, inhibit, h24, fmt_bin};
      A_STAT: rd_data = {5'b0, af, uf, uip};
      default: rd_data = 8'h00;
    endcase
  end

  // R8
  inhibit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !wr_en) |=> $stable(utm));
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |=> uf);
  // R2
  sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && sec_wrap && !wr_en) |=> (itm.sec == 8'h00));
  // R5
  month_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && mon_wrap && !wr_en) |=> (itm.dom == 8'h01));
  // R5
  year_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && yr_wrap && !wr_en) |=> (itm.mon == 8'h01));
  // R10
  alarm_at_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(upd_go));
endmodule

// File: tb/sim_rtc_cal_engine.sv
`timescale 1ns/1ps
module sim_rtc_cal_engine;
  localparam int TPS  = 4;
  localparam int LEAD = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;

  int n_chk = 0, n_bad = 0, phase = 0;
  bit done = 1'b0;

  int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr;
  bit m_bin, m_h24, m_inh;

  always #2.5 clk = ~clk;

  rtc_cal_engine #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  function automatic logic [7:0] b_enc(int v, bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] b_hr(int h, bit bin, bit h24);
    int k;
    if (h24) return b_enc(h, bin);
    k = h % 12;
    if (k == 0) k = 12;
    return b_enc(k, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int b_mdays(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = m_dow % 7 + 1;
          m_dom++;
          if (m_dom > b_mdays(m_mon, m_yr)) begin
            m_dom = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd_status(output logic [7:0] d);
    @(negedge clk);
    addr = 4'd11; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_tick(output bit upd);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    upd = (phase == TPS - 1);
    phase = (phase + 1) % TPS;
  endtask

  task automatic next_second();
    bit u;
    u = 1'b0;
    while (!u) pulse_tick(u);
    model_step();
  endtask

  task automatic load_model();
    wr(4'd10, {5'b0, m_inh, m_h24, m_bin});
    wr(4'd0, b_enc(m_sec, m_bin));
    wr(4'd2, b_enc(m_min, m_bin));
    wr(4'd4, b_hr(m_hr, m_bin, m_h24));
    wr(4'd6, b_enc(m_dow, m_bin));
    wr(4'd7, b_enc(m_dom, m_bin));
    wr(4'd8, b_enc(m_mon, m_bin));
    wr(4'd9, b_enc(m_yr, m_bin));
  endtask

  task automatic check_time(string tag);
    logic [7:0] v;
    peek(4'd0, v); check({tag, " sec"}, v, b_enc(m_sec, m_bin));
    peek(4'd2, v); check({tag, " min"}, v, b_enc(m_min, m_bin));
    peek(4'd4, v); check({tag, " hr"},  v, b_hr(m_hr, m_bin, m_h24));
    peek(4'd6, v); check({tag, " dow"}, v, b_enc(m_dow, m_bin));
    peek(4'd7, v); check({tag, " dom"}, v, b_enc(m_dom, m_bin));
    peek(4'd8, v); check({tag, " mon"}, v, b_enc(m_mon, m_bin));
    peek(4'd9, v); check({tag, " yr"},  v, b_enc(m_yr, m_bin));
  endtask

  task automatic set_tm(int hr, int mi, int s, int dw, int dm, int mo, int yr);
    m_hr = hr; m_min = mi; m_sec = s; m_dow = dw; m_dom = dm; m_mon = mo; m_yr = yr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit u;
    void'($urandom(32'd20240611));
    set_tm(0, 0, 0, 1, 1, 1, 0);
    m_bin = 1'b0; m_h24 = 1'b1; m_inh = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    check_time("R12 reset");
    peek(4'd1, v);  check("R12 alarm", v, 8'h00);
    peek(4'd10, v); check("R12 ctl", v, 8'h02);
    peek(4'd11, v); check("R12 status", v, 8'h00);
    // R1 unmapped address
    peek(4'd14, v); check("R1 unmapped", v, 8'h00);

    // R7 update-in-progress window, phase starts at 0
    pulse_tick(u); peek(4'd11, v); check("R7 uip low", v, 8'h00);
    pulse_tick(u); peek(4'd11, v); check("R7 uip rise", v, 8'h01);
    pulse_tick(u); peek(4'd11, v); check("R7 uip held", v, 8'h01);
    pulse_tick(u); model_step();
    peek(4'd11, v); check("R7 uip clear uf set", v, 8'h02);
    check_time("R2 first second");
    // R11 clear on read
    rd_status(v); check("R11 read value", v, 8'h02);
    peek(4'd11, v); check("R11 cleared", v, 8'h00);

    // R5 year end in BCD 24h
    set_tm(23, 59, 58, 7, 31, 12, 99); load_model();
    next_second(); check_time("R2 pre-roll");
    next_second(); check_time("R5 year end");

    // R6 leap handling
    set_tm(23, 59, 59, 3, 28, 2, 4);  load_model(); next_second(); check_time("R6 leap 04");
    set_tm(23, 59, 59, 3, 28, 2, 3);  load_model(); next_second(); check_time("R6 common 03");
    set_tm(23, 59, 59, 3, 28, 2, 0);  load_model(); next_second(); check_time("R6 leap 00");
    set_tm(23, 59, 59, 3, 30, 4, 21); load_model(); next_second(); check_time("R6 april end");

    // R3 R4 12-hour binary
    m_bin = 1'b1; m_h24 = 1'b0;
    set_tm(11, 59, 59, 2, 10, 5, 30); load_model();
    peek(4'd10, v); check("R3 ctl", v, 8'h01);
    next_second(); check_time("R4 noon");
    peek(4'd4, v); check("R4 noon byte", v, 8'h8C);
    set_tm(23, 59, 59, 2, 10, 5, 30); load_model(); next_second(); check_time("R4 midnight");
    peek(4'd4, v); check("R4 midnight byte", v, 8'h0C);
    // R4 BCD 12-hour noon
    m_bin = 1'b0;
    set_tm(11, 59, 59, 2, 10, 5, 30); load_model(); next_second();
    peek(4'd4, v); check("R4 bcd noon byte", v, 8'h92);

    // R8 inhibit freeze and release, R9 writes to both copies
    m_bin = 1'b0; m_h24 = 1'b1; m_inh = 1'b0;
    set_tm(10, 20, 40, 4, 15, 6, 50); load_model();
    wr(4'd10, 8'h06);
    next_second();
    peek(4'd0, v); check("R8 frozen sec", v, 8'h40);
    next_second();
    peek(4'd0, v); check("R8 still frozen", v, 8'h40);
    wr(4'd0, 8'h30); m_sec = 30;
    peek(4'd0, v); check("R9 write visible", v, 8'h30);
    wr(4'd10, 8'h02);
    next_second(); check_time("R8 release");

    // R10 alarm with wildcards and R11 clear
    rd_status(v);
    wr(4'd1, b_enc((m_sec + 2) % 60, m_bin));
    wr(4'd3, 8'hC0);
    wr(4'd5, 8'hFF);
    next_second(); peek(4'd11, v); check("R10 no match yet", v & 8'h04, 8'h00);
    next_second(); peek(4'd11, v); check("R10 wildcard match", v & 8'h04, 8'h04);
    rd_status(v); check("R11 alarm read", v & 8'h06, 8'h06);
    peek(4'd11, v); check("R11 alarm cleared", v & 8'h06, 8'h00);
    // R10 exact match on all three bytes
    wr(4'd1, b_enc((m_sec + 1) % 60, m_bin));
    wr(4'd3, b_enc(m_min, m_bin));
    wr(4'd5, b_hr(m_hr, m_bin, m_h24));
    next_second(); peek(4'd11, v); check("R10 exact match", v & 8'h04, 8'h04);
    wr(4'd3, b_enc((m_min + 1) % 60, m_bin));
    wr(4'd1, b_enc((m_sec + 1) % 60, m_bin));
    rd_status(v);
    next_second(); peek(4'd11, v); check("R10 minute mismatch", v & 8'h04, 8'h00);

    // random vectors, R2 R3 R4 R5 R6
    wr(4'd1, 8'h00); wr(4'd3, 8'h00); wr(4'd5, 8'h00);
    for (int i = 0; i < 40; i++) begin
      m_bin = 1'($urandom); m_h24 = 1'($urandom); m_inh = 1'b0;
      m_yr  = $urandom_range(0, 99);
      m_mon = ($urandom_range(0, 3) == 0) ? 2 : $urandom_range(1, 12);
      m_dom = ($urandom_range(0, 1) == 0) ? b_mdays(m_mon, m_yr)
                                          : $urandom_range(1, b_mdays(m_mon, m_yr));
      m_dow = $urandom_range(1, 7);
      m_hr  = ($urandom_range(0, 1) == 0) ? (($urandom_range(0, 1) == 0) ? 23 : 11)
                                          : $urandom_range(0, 23);
      m_min = ($urandom_range(0, 2) != 0) ? 59 : $urandom_range(0, 59);
      m_sec = ($urandom_range(0, 3) != 0) ? 59 : $urandom_range(0, 59);
      if ($urandom_range(0, 5) == 0) m_mon = 12;
      if (m_dom > b_mdays(m_mon, m_yr)) m_dom = b_mdays(m_mon, m_yr);
      load_model();
      next_second();
      check_time("R2 R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule